// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Port

This block is a configuration register file that a host reaches through two byte-wide I/O locations: an index location that names a register and a data location that reads or writes the register named. After reset the file is locked. Data-location writes do nothing and data-location reads return 0xFF. A host unlocks it by writing the two key bytes 0x51 then 0x23 to the index location. It locks the file again by writing the exit byte 0xBB there.

Registers below 0x30 are global. Register 0x07 selects one of nine logical devices. Registers from 0x30 upward are banked, so each logical device has its own copy of an activate flag, a 16-bit I/O base, two IRQ numbers, a DMA channel and four mode bytes. Every bank is driven out in parallel on flat output buses, slice g belonging to device g. The surrounding device logic consumes these outputs. The global common-I/O control byte and the three power/polarity bytes are driven out the same way.

Top module: `cfg_port_top`

## Requirements
- R1: After reset the file is locked. While locked, a data-location write changes no output, and `busRdData` reads 0xFF. Every bank starts with activate 0, base 0x0000, IRQs 0, mode bytes 0 and DMA channel 0x04.
- R2: Writing 0x51 and then 0x23 as two consecutive index-location writes unlocks the file. From the next cycle, a read of the data location (`busPort`=1) returns the indexed register.
- R3: After 0x51, an index byte other than 0x23 or 0x51 abandons the key and leaves the file locked. A repeated 0x51 restarts the key, so the sequence 0x51, 0x51, 0x23 unlocks. Key bytes written to the data location do not count.
- R4: The index byte 0xBB, written while unlocked, locks the file. Later data writes are ignored and reads return 0xFF until the key is given again.
- R5: Global register 0x07 stores the low four bits of the written byte as the selected device number and reads back as {0000, number}. Devices 0 to 8 are valid.
- R6: Banked register 0x30 bit 0 sets `devActive[n]` for the selected device n. The register reads back as {0000000, flag}.
- R7: Banked registers 0x60 and 0x61 set the high and low bytes of `devBase[n*16 +: 16]`.
- R8: Banked registers 0x70, 0x72 and 0x74 set `devIrq`, `devIrq2` and `devDma` (each 8 bits per device) for the selected device.
- R9: Banked registers 0xF0 to 0xF3 set mode byte m (m = index - 0xF0) at `devMode[(n*4+m)*8 +: 8]`.
- R10: While the selected number is 9 or higher, banked writes change no bank, and banked reads return 0xFF.
- R11: Writing a byte with bit 0 set to global register 0x02 returns every bank to its reset values in the next cycle. The selected device and the other globals are kept, and 0x02 reads 0x00.
- R12: Global register 0x03 drives `glbCio`. Registers 0x22, 0x23 and 0x24 drive bytes 0, 1 and 2 of `glbPower`. All four read back.
- R13: An index that names no register reads 0xFF. A write to it changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busWr | input | 1 | Write strobe for one cycle |
| busPort | input | 1 | 0 = index location, 1 = data location |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Data-location read value (0xFF when locked or when busPort=0) |
| selDev | output | 4 | Selected logical device number |
| devActive | output | 9 | Activate flag per device |
| devBase | output | 144 | 16-bit I/O base per device |
| devIrq | output | 72 | Primary IRQ per device |
| devIrq2 | output | 72 | Second IRQ per device |
| devDma | output | 72 | DMA channel per device |
| devMode | output | 288 | Four mode bytes per device |
| glbCio | output | 8 | Common-I/O control byte |
| glbPower | output | 24 | Power-down and polarity bytes |

## Verification
Every register write takes effect at the clock edge that samples the strobe, so the outputs and the read-back path change one cycle after the write. Reads come through a combinational path from the current index and the stored values. The bench drives each access on a falling edge and returns the strobe low on the next falling edge. It samples outputs and `busRdData` after that second falling edge, which is half a cycle after the updating edge. Lock-state changes are due one cycle after the index byte that causes them, and the lock checks read the data location after the same half-cycle wait.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h51;
  localparam logic [7:0] KEY_SECOND = 8'h23;
  localparam logic [7:0] EXIT_BYTE  = 8'hBB;

  localparam logic [7:0] REG_SRST   = 8'h02;
  localparam logic [7:0] REG_CIO    = 8'h03;
  localparam logic [7:0] REG_LDN    = 8'h07;
  localparam logic [7:0] REG_PWR0   = 8'h22;
  localparam logic [7:0] BANK_BASE  = 8'h30;
  localparam logic [7:0] REG_ACT    = 8'h30;
  localparam logic [7:0] REG_BASEHI = 8'h60;
  localparam logic [7:0] REG_BASELO = 8'h61;
  localparam logic [7:0] REG_IRQ    = 8'h70;
  localparam logic [7:0] REG_IRQ2   = 8'h72;
  localparam logic [7:0] REG_DMA    = 8'h74;
  localparam logic [7:0] REG_MODE0  = 8'hF0;

  localparam logic [7:0] DMA_DEFAULT = 8'h04;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_t;

  typedef struct packed {
    logic       open;
    logic       wrEn;
    logic       bankArea;
    logic       softRst;
    logic [7:0] idx;
    logic [7:0] dat;
  } cfg_strb_t;
endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic       busPort,
  input  logic [7:0] busWrData,
  output cfg_strb_t  strb,
  output logic       cfgOpen,
  output logic       keyHalf,
  output logic [7:0] curIdx
);
  lock_state_t lockState;
  logic idxWr;
  logic datWr;

  assign idxWr = busWr && !busPort;
  assign datWr = busWr && busPort && (lockState == LK_OPEN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockState <= LK_LOCKED;
      curIdx    <= 8'h00;
    end else if (idxWr) begin
      case (lockState)
        LK_LOCKED: begin
          if (busWrData == KEY_FIRST) lockState <= LK_HALF;
        end
        LK_HALF: begin
          if (busWrData == KEY_SECOND)     lockState <= LK_OPEN;
          else if (busWrData == KEY_FIRST) lockState <= LK_HALF;
          else                             lockState <= LK_LOCKED;
        end
        LK_OPEN: begin
          if (busWrData == EXIT_BYTE) lockState <= LK_LOCKED;
          else                        curIdx    <= busWrData;
        end
        default: lockState <= LK_LOCKED;
      endcase
    end
  end

  assign cfgOpen = (lockState == LK_OPEN);
  assign keyHalf = (lockState == LK_HALF);

  always_comb begin
    strb          = '0;
    strb.open     = cfgOpen;
    strb.wrEn     = datWr;
    strb.idx      = curIdx;
    strb.dat      = busWrData;
    strb.bankArea = (curIdx >= BANK_BASE);
    strb.softRst  = datWr && (curIdx == REG_SRST) && busWrData[0];
  end
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import cfg_pkg::*;
#(
  parameter int NUM_DEV  = 9,
  parameter int NUM_MODE = 4,
  parameter int LDN_W    = 4,
  parameter int NUM_PWR  = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cfg_strb_t                    strb,
  input  logic                         busPort,
  output logic [7:0]                   busRdData,
  output logic [LDN_W-1:0]             selDev,
  output logic [NUM_DEV-1:0]           devActive,
  output logic [NUM_DEV*16-1:0]        devBase,
  output logic [NUM_DEV*8-1:0]         devIrq,
  output logic [NUM_DEV*8-1:0]         devIrq2,
  output logic [NUM_DEV*8-1:0]         devDma,
  output logic [NUM_DEV*NUM_MODE*8-1:0] devMode,
  output logic [7:0]                   glbCio,
  output logic [NUM_PWR*8-1:0]         glbPower
);
  logic globalWe;
  logic devValid;
  logic [7:0] rdVal;

  assign globalWe = strb.wrEn && !strb.bankArea;
  assign devValid = (int'(selDev) < NUM_DEV);

  // Global registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selDev   <= '0;
      glbCio   <= 8'h00;
      glbPower <= '0;
    end else if (globalWe) begin
      if (strb.idx == REG_LDN) selDev <= strb.dat[LDN_W-1:0];
      if (strb.idx == REG_CIO) glbCio <= strb.dat;
      for (int p = 0; p < NUM_PWR; p++) begin
        if (strb.idx == REG_PWR0 + 8'(p)) glbPower[p*8 +: 8] <= strb.dat;
      end
    end
  end

  // Banked registers, one copy per logical device
  for (genvar g = 0; g < NUM_DEV; g++) begin : gBank
    logic                      bankWe;
    logic                      actR;
    logic [15:0]               baseR;
    logic [7:0]                irqR;
    logic [7:0]                irq2R;
    logic [7:0]                dmaR;
    logic [NUM_MODE-1:0][7:0]  modeR;

    assign bankWe = strb.wrEn && strb.bankArea && (int'(selDev) == g);

    always_ff @(posedge clk) begin
      if (!rstN || strb.softRst) begin
        actR  <= 1'b0;
        baseR <= 16'h0000;
        irqR  <= 8'h00;
        irq2R <= 8'h00;
        dmaR  <= DMA_DEFAULT;
        modeR <= '0;
      end else if (bankWe) begin
        case (strb.idx)
          REG_ACT:    actR          <= strb.dat[0];
          REG_BASEHI: baseR[15:8]   <= strb.dat;
          REG_BASELO: baseR[7:0]    <= strb.dat;
          REG_IRQ:    irqR          <= strb.dat;
          REG_IRQ2:   irq2R         <= strb.dat;
          REG_DMA:    dmaR          <= strb.dat;
          default: begin
            for (int m = 0; m < NUM_MODE; m++) begin
              if (strb.idx == REG_MODE0 + 8'(m)) modeR[m] <= strb.dat;
            end
          end
        endcase
      end
    end

    assign devActive[g]                        = actR;
    assign devBase[g*16 +: 16]                 = baseR;
    assign devIrq[g*8 +: 8]                    = irqR;
    assign devIrq2[g*8 +: 8]                   = irq2R;
    assign devDma[g*8 +: 8]                    = dmaR;
    assign devMode[g*NUM_MODE*8 +: NUM_MODE*8] = modeR;
  end

  // Read-back mux for the data location
  always_comb begin
    int sel;
    sel   = int'(selDev);
    rdVal = 8'hFF;
    if (!strb.bankArea) begin
      case (strb.idx)
        REG_SRST: rdVal = 8'h00;
        REG_CIO:  rdVal = glbCio;
        REG_LDN:  rdVal = 8'(selDev);
        default: begin
          for (int p = 0; p < NUM_PWR; p++) begin
            if (strb.idx == REG_PWR0 + 8'(p)) rdVal = glbPower[p*8 +: 8];
          end
        end
      endcase
    end else if (devValid) begin
      case (strb.idx)
        REG_ACT:    rdVal = {7'b0, devActive[sel]};
        REG_BASEHI: rdVal = devBase[sel*16+8 +: 8];
        REG_BASELO: rdVal = devBase[sel*16 +: 8];
        REG_IRQ:    rdVal = devIrq[sel*8 +: 8];
        REG_IRQ2:   rdVal = devIrq2[sel*8 +: 8];
        REG_DMA:    rdVal = devDma[sel*8 +: 8];
        default: begin
          for (int m = 0; m < NUM_MODE; m++) begin
            if (strb.idx == REG_MODE0 + 8'(m)) rdVal = devMode[(sel*NUM_MODE+m)*8 +: 8];
          end
        end
      endcase
    end
  end

  assign busRdData = (strb.open && busPort) ? rdVal : 8'hFF;
endmodule

// File: rtl/cfg_port_top.sv
module cfg_port_top
  import cfg_pkg::*;
#(
  parameter int NUM_DEV  = 9,
  parameter int NUM_MODE = 4,
  parameter int NUM_PWR  = 3,
  parameter int LDN_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWr,
  input  logic                          busPort,
  input  logic [7:0]                    busWrData,
  output logic [7:0]                    busRdData,
  output logic [LDN_W-1:0]              selDev,
  output logic [NUM_DEV-1:0]            devActive,
  output logic [NUM_DEV*16-1:0]         devBase,
  output logic [NUM_DEV*8-1:0]          devIrq,
  output logic [NUM_DEV*8-1:0]          devIrq2,
  output logic [NUM_DEV*8-1:0]          devDma,
  output logic [NUM_DEV*NUM_MODE*8-1:0] devMode,
  output logic [7:0]                    glbCio,
  output logic [NUM_PWR*8-1:0]          glbPower
);
  cfg_strb_t  strb;
  logic       cfgOpen;
  logic       keyHalf;
  logic [7:0] curIdx;

  cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busPort(busPort),
    .busWrData(busWrData), .strb(strb), .cfgOpen(cfgOpen),
    .keyHalf(keyHalf), .curIdx(curIdx)
  );

  cfg_datapath #(
    .NUM_DEV(NUM_DEV), .NUM_MODE(NUM_MODE), .LDN_W(LDN_W), .NUM_PWR(NUM_PWR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busPort(busPort),
    .busRdData(busRdData), .selDev(selDev), .devActive(devActive),
    .devBase(devBase), .devIrq(devIrq), .devIrq2(devIrq2), .devDma(devDma),
    .devMode(devMode), .glbCio(glbCio), .glbPower(glbPower)
  );
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int NUM_DEV = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWr,
  input logic               busPort,
  input logic [7:0]         busWrData,
  input logic [7:0]         busRdData,
  input logic [NUM_DEV-1:0] devActive,
  input logic [NUM_DEV*16-1:0] devBase,
  input logic               cfgOpen,
  input logic               keyHalf,
  input logic [7:0]         curIdx
);
  assert_locked_ignore_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgOpen && busWr && busPort) |=> ($stable(devActive) && $stable(devBase)));

  assert_locked_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOpen |-> (busRdData == 8'hFF));

  assert_key_open_R2: assert property (@(posedge clk) disable iff (!rstN)
    (keyHalf && busWr && !busPort && busWrData == 8'h23) |=> cfgOpen);

  assert_key_break_R3: assert property (@(posedge clk) disable iff (!rstN)
    (keyHalf && busWr && !busPort && busWrData != 8'h23 && busWrData != 8'h51)
    |=> (!cfgOpen && !keyHalf));

  assert_exit_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOpen && busWr && !busPort && busWrData == 8'hBB) |=> !cfgOpen);

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOpen && busWr && busPort && curIdx == 8'h02 && busWrData[0])
    |=> (devActive == '0));
endmodule

bind cfg_port_top cfg_port_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busPort(busPort),
  .busWrData(busWrData), .busRdData(busRdData), .devActive(devActive),
  .devBase(devBase), .cfgOpen(cfgOpen), .keyHalf(keyHalf), .curIdx(curIdx)
);

// File: tb/test_cfg_port_top.sv
module test_cfg_port_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWr = 1'b0;
  logic         busPort = 1'b0;
  logic [7:0]   busWrData = 8'h00;
  logic [7:0]   busRdData;
  logic [3:0]   selDev;
  logic [8:0]   devActive;
  logic [143:0] devBase;
  logic [71:0]  devIrq, devIrq2, devDma;
  logic [287:0] devMode;
  logic [7:0]   glbCio;
  logic [23:0]  glbPower;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_top i_cfg_port_top (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busPort(busPort),
    .busWrData(busWrData), .busRdData(busRdData), .selDev(selDev),
    .devActive(devActive), .devBase(devBase), .devIrq(devIrq),
    .devIrq2(devIrq2), .devDma(devDma), .devMode(devMode),
    .glbCio(glbCio), .glbPower(glbPower)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic port, input logic [7:0] b);
    @(negedge clk);
    busWr = 1'b1; busPort = port; busWrData = b;
    @(negedge clk);
    busWr = 1'b0; busPort = 1'b1;
  endtask

  task automatic wrIdx(input logic [7:0] b); busWrite(1'b0, b); endtask
  task automatic wrDat(input logic [7:0] b); busWrite(1'b1, b); endtask

  task automatic setReg(input logic [7:0] i, input logic [7:0] v);
    wrIdx(i); wrDat(v);
  endtask

  task automatic getReg(input logic [7:0] i, output logic [7:0] v);
    wrIdx(i);
    busPort = 1'b1;
    #1 v = busRdData;
  endtask

  task automatic unlock();
    wrIdx(8'h51); wrIdx(8'h23);
  endtask

  task automatic testReset();
    busPort = 1'b1;
    #1;
    check("R1 locked read", 32'(busRdData), 32'hFF);
    check("R1 active default", 32'(devActive), 32'h0);
    check("R1 dma default", 32'(devDma[0*8 +: 8]), 32'h04);
    check("R1 base default", 32'(devBase[8*16 +: 16]), 32'h0);
    wrDat(8'h33);
    check("R1 locked write ignored", 32'(devActive), 32'h0);
    check("R1 locked read after write", 32'(busRdData), 32'hFF);
  endtask

  task automatic testBanks();
    logic [7:0] v;
    unlock();
    getReg(8'h07, v);
    check("R2 unlocked read", 32'(v), 32'h00);
    setReg(8'h07, 8'h05);
    getReg(8'h07, v);
    check("R5 ldn readback", 32'(v), 32'h05);
    check("R5 selDev", 32'(selDev), 32'h5);
    setReg(8'h30, 8'h01);
    check("R6 activate", 32'(devActive), 32'h020);
    getReg(8'h30, v);
    check("R6 readback", 32'(v), 32'h01);
    setReg(8'h60, 8'h03); setReg(8'h61, 8'hF8);
    check("R7 base", 32'(devBase[5*16 +: 16]), 32'h03F8);
    getReg(8'h60, v);
    check("R7 base hi readback", 32'(v), 32'h03);
    setReg(8'h70, 8'h04); setReg(8'h72, 8'h0C); setReg(8'h74, 8'h02);
    check("R8 irq", 32'(devIrq[5*8 +: 8]), 32'h04);
    check("R8 irq2", 32'(devIrq2[5*8 +: 8]), 32'h0C);
    check("R8 dma", 32'(devDma[5*8 +: 8]), 32'h02);
    check("R8 other bank untouched", 32'(devDma[4*8 +: 8]), 32'h04);
    for (int m = 0; m < 4; m++) setReg(8'hF0 + 8'(m), 8'hA0 + 8'(m));
    check("R9 mode bytes", devMode[5*32 +: 32], 32'hA3A2A1A0);
    getReg(8'hF2, v);
    check("R9 mode readback", 32'(v), 32'hA2);
  endtask

  task automatic testUnimpl();
    logic [7:0] v;
    setReg(8'h40, 8'h77);
    getReg(8'h40, v);
    check("R13 bank unimpl read", 32'(v), 32'hFF);
    check("R13 bank unimpl no effect", 32'(devBase[5*16 +: 16]), 32'h03F8);
    check("R13 active unchanged", 32'(devActive), 32'h020);
    setReg(8'h10, 8'h55);
    getReg(8'h10, v);
    check("R13 global unimpl read", 32'(v), 32'hFF);
    check("R13 global unimpl no effect", 32'(glbCio), 32'h00);
  endtask

  task automatic testGlobals();
    logic [7:0] v;
    setReg(8'h03, 8'h83);
    check("R12 cio out", 32'(glbCio), 32'h83);
    getReg(8'h03, v);
    check("R12 cio readback", 32'(v), 32'h83);
    setReg(8'h22, 8'h11); setReg(8'h23, 8'h22); setReg(8'h24, 8'h33);
    check("R12 power out", 32'(glbPower), 32'h332211);
    getReg(8'h23, v);
    check("R12 power readback", 32'(v), 32'h22);
  endtask

  task automatic testBadDev();
    logic [7:0] v;
    setReg(8'h07, 8'h0B);
    setReg(8'h30, 8'h01);
    check("R10 bad dev write ignored", 32'(devActive), 32'h020);
    getReg(8'h30, v);
    check("R10 bad dev read", 32'(v), 32'hFF);
    setReg(8'h07, 8'h17);
    check("R5 low four bits kept", 32'(selDev), 32'h7);
  endtask

  task automatic testSoftReset();
    logic [7:0] v;
    setReg(8'h07, 8'h03);
    setReg(8'h30, 8'h01);
    check("R11 pre active", 32'(devActive), 32'h028);
    setReg(8'h02, 8'h01);
    check("R11 active cleared", 32'(devActive), 32'h0);
    check("R11 base cleared", 32'(devBase[5*16 +: 16]), 32'h0);
    check("R11 dma default", 32'(devDma[5*8 +: 8]), 32'h04);
    check("R11 mode cleared", devMode[5*32 +: 32], 32'h0);
    getReg(8'h02, v);
    check("R11 srst reads zero", 32'(v), 32'h00);
    check("R11 ldn kept", 32'(selDev), 32'h3);
    check("R11 cio kept", 32'(glbCio), 32'h83);
  endtask

  task automatic testExit();
    logic [7:0] v;
    setReg(8'h30, 8'h01);
    check("R4 pre exit active", 32'(devActive), 32'h008);
    wrIdx(8'hBB);
    #1;
    check("R4 locked read", 32'(busRdData), 32'hFF);
    wrDat(8'h00);
    check("R4 write after exit ignored", 32'(devActive), 32'h008);
    wrIdx(8'h51); wrIdx(8'h44); wrIdx(8'h23);
    #1;
    check("R3 broken key stays locked", 32'(busRdData), 32'hFF);
    wrDat(8'h51); wrDat(8'h23);
    #1;
    check("R3 data-port key ignored", 32'(busRdData), 32'hFF);
    wrIdx(8'h51); wrIdx(8'h51); wrIdx(8'h23);
    getReg(8'h07, v);
    check("R3 restarted key unlocks", 32'(v), 32'h03);
    getReg(8'h30, v);
    check("R2 state kept across lock", 32'(v), 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBanks();
    testUnimpl();
    testGlobals();
    testBadDev();
    testSoftReset();
    testExit();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule